// File: doc/BRIEF.md
# Pipelined Signed Array Multiplier

This block multiplies two W-bit two's-complement operands. It accepts a new operand pair on every clock and returns the full 2W-bit product after a fixed number of cycles. The datapath is a grid of full-adder cells arranged as rows of carry-save adders. Each row folds one partial-product row into a running sum word and a running carry word. Both words are registered after every row. Carries move straight down to the next row, and the sum bits move diagonally. The operands are delayed through registers so that each row sees the pair that belongs to its partial sums. A two-bit-per-stage ripple-carry adder follows the array and is pipelined as well. It resolves the final carry-save pair into the product while the carry chains from the low columns towards the high ones.

Signed operands need no sign extension. In any partial-product bit where exactly one of the two operand bits is a sign bit, the adder uses the complement of that bit. Two constant ones are added at columns W and 2W-1, and the result is kept modulo 2^(2W). Every bit that enters the adders therefore has a positive weight. A valid flag travels through every stage beside the data, so the block needs no stall logic. An active-low reset clears the valid flags. The reset acts asynchronously and is released in step with the clock.

Top module: `bw_array_mult`

## Requirements
- R1: For any pair of W-bit two's-complement operands accepted by the block, `out_prod` equals their exact signed product as a 2W-bit two's-complement value.
- R2: A pair is accepted at a rising clock edge where `in_valid` is 1. At the 2W-1-th rising edge counted from the accepting edge (that edge included), `out_valid` goes to 1 together with that pair's product, and it stays 1 for one cycle.
- R3: Pairs offered on consecutive cycles are all accepted, and their products come out on consecutive cycles in the same order.
- R4: While `rst_n` is 0, `out_valid` is 0. After reset, `out_valid` stays 0 until the first accepted pair reaches the output.
- R5: The most negative operand multiplied by itself (binary 1 followed by W-1 zeros, on both inputs) gives +2^(2W-2). For the default W=8 that is 0x4000.
- R6: Products in which each operand is 0, -1 (all ones), +1, the largest positive value or the most negative value are exact.
- R7: Operand values present at an edge where `in_valid` is 0 are ignored. No `out_valid` pulse appears 2W-1 edges later for that slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| in_valid | input | 1 | Qualifies `in_a` and `in_b` at this edge |
| in_a | input | W | Multiplicand, two's complement |
| in_b | input | W | Multiplier, two's complement |
| out_valid | output | 1 | `out_prod` holds a product this cycle |
| out_prod | output | 2W | Signed product, two's complement |

## Verification
The properties take for granted that `in_valid` is a clean 0 or 1 at every edge once reset has been released. They also take for granted that the operand buses are only interpreted when `in_valid` is high, so garbage on the buses while `in_valid` is low must not matter. The stimulus keeps `in_valid` low through reset and for several cycles after release, while the two-stage reset release finishes. It then drives the operands at the falling edge, and during idle slots it deliberately puts random values on the operand buses. Corner-case pairs are sent first as an unbroken burst, followed by a long back-to-back random burst and then random traffic with random gaps. These phases exercise the in-flight count at its limit as well as the case where the pipeline drains completely.

// File: rtl/bw_pkg.sv
`timescale 1ns/1ps
package bw_pkg;

  localparam int unsigned BW_DEF_W = 8;

  // Cycles from the accepting edge to the product: (W-1) array rows after
  // the first, plus W two-bit ripple stages.
  function automatic int unsigned bw_latency(input int unsigned w);
    return 2 * w - 1;
  endfunction

endpackage

// File: rtl/bw_pp_row.sv
`timescale 1ns/1ps
// One partial-product row placed at its column offset. Bits that carry a
// negative weight (exactly one factor is a sign bit) are complemented.
module bw_pp_row #(
  parameter int unsigned W   = 8,
  parameter int unsigned ROW = 0
) (
  input  logic [W-1:0]   a_i,
  input  logic           b_bit,
  output logic [2*W-1:0] row_o
);

  always_comb begin
    row_o = '0;
    for (int j = 0; j < W; j++) begin
      row_o[ROW + j] = (a_i[j] & b_bit) ^ ((j == W - 1) != (ROW == W - 1));
    end
  end

endmodule

// File: rtl/bw_array_stage.sv
`timescale 1ns/1ps
// One array row: a carry-save step that folds partial-product row ROW into
// the running sum/carry pair, every cell registered, operands skewed along.
module bw_array_stage #(
  parameter int unsigned W   = 8,
  parameter int unsigned ROW = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             v_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic [2*W-1:0]   s_i,
  input  logic [2*W-1:0]   c_i,
  output logic             v_o,
  output logic [W-1:0]     a_o,
  output logic [W-1:0]     b_o,
  output logic [2*W-1:0]   s_o,
  output logic [2*W-1:0]   c_o
);

  localparam int unsigned TW = 2 * W;

  logic [TW-1:0] pp;
  logic [TW-1:0] s_n;
  logic [TW-1:0] c_n;

  bw_pp_row #(.W(W), .ROW(ROW)) u_pp (
    .a_i   (a_i),
    .b_bit (b_i[ROW]),
    .row_o (pp)
  );

  // Sum bits stay in their column (diagonal in the array picture); carries
  // move one column up (straight down to the next row's cell).
  always_comb begin
    s_n = s_i ^ c_i ^ pp;
    c_n = ((s_i & c_i) | (s_i & pp) | (c_i & pp)) << 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_o <= 1'b0;
    else        v_o <= v_i;
  end

  always_ff @(posedge clk) begin
    if (v_i) begin
      a_o <= a_i;
      b_o <= b_i;
      s_o <= s_n;
      c_o <= c_n;
    end
  end

  // Carry-save step keeps the represented value (modulo 2^TW).
  p_csa_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
    v_o |-> (s_o + c_o) == $past(s_i + c_i + pp));

endmodule

// File: rtl/bw_ripple_stage.sv
`timescale 1ns/1ps
// One slice of the pipelined ripple-carry final adder: resolves columns
// 2P and 2P+1, writes the result bits into the sum word, clears the carry
// word there and hands the slice carry to the next stage.
module bw_ripple_stage #(
  parameter int unsigned W = 8,
  parameter int unsigned P = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             v_i,
  input  logic [2*W-1:0]   s_i,
  input  logic [2*W-1:0]   c_i,
  input  logic             cy_i,
  output logic             v_o,
  output logic [2*W-1:0]   s_o,
  output logic [2*W-1:0]   c_o,
  output logic             cy_o
);

  localparam int unsigned TW = 2 * W;
  localparam int unsigned LO = 2 * P;

  logic [2:0]    dsum;
  logic [TW-1:0] s_n;
  logic [TW-1:0] c_n;

  always_comb begin
    dsum = {1'b0, s_i[LO+1:LO]} + {1'b0, c_i[LO+1:LO]} + {2'b00, cy_i};
    s_n  = s_i;
    s_n[LO +: 2] = dsum[1:0];
    c_n  = c_i;
    c_n[LO +: 2] = 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_o <= 1'b0;
    else        v_o <= v_i;
  end

  always_ff @(posedge clk) begin
    if (v_i) begin
      s_o  <= s_n;
      c_o  <= c_n;
      cy_o <= dsum[2];
    end
  end

  // The slice moves value between words without changing the total.
  p_ripple_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
    v_o |-> (s_o + c_o + (TW'(cy_o) << (LO + 2))) ==
            $past(s_i + c_i + (TW'(cy_i) << LO)));

endmodule

// File: rtl/bw_array_mult.sv
`timescale 1ns/1ps
module bw_array_mult
  import bw_pkg::*;
#(
  parameter int unsigned W = BW_DEF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [W-1:0]     in_a,
  input  logic [W-1:0]     in_b,
  output logic             out_valid,
  output logic [2*W-1:0]   out_prod
);

  localparam int unsigned TW  = 2 * W;
  localparam int unsigned LAT = bw_latency(W);
  localparam int unsigned CW  = $clog2(LAT + 1) + 1;
  // Sign-handling constant: ones at column W and column 2W-1.
  localparam logic [TW-1:0] FIX = (TW'(1) << W) | (TW'(1) << (TW - 1));

  // ---------------- reset release ----------------
  logic [1:0] rsync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_int_n = rsync[1];

  // ---------------- array rows ----------------
  logic          v_p [W];
  logic [TW-1:0] s_p [W];
  logic [TW-1:0] c_p [W];
  logic [W-1:0]  a_p [W-1];
  logic [W-1:0]  b_p [W-1];
  logic [W-1:0]  a_tail_unused;
  logic [W-1:0]  b_tail_unused;

  assign v_p[0] = in_valid;
  assign s_p[0] = FIX;
  assign a_p[0] = in_a;
  assign b_p[0] = in_b;

  bw_pp_row #(.W(W), .ROW(0)) u_row0 (
    .a_i   (in_a),
    .b_bit (in_b[0]),
    .row_o (c_p[0])
  );

  for (genvar r = 1; r < W; r++) begin : g_row
    if (r < W - 1) begin : g_mid
      bw_array_stage #(.W(W), .ROW(r)) u_stage (
        .clk (clk), .rst_n (rst_int_n),
        .v_i (v_p[r-1]), .a_i (a_p[r-1]), .b_i (b_p[r-1]),
        .s_i (s_p[r-1]), .c_i (c_p[r-1]),
        .v_o (v_p[r]),   .a_o (a_p[r]),   .b_o (b_p[r]),
        .s_o (s_p[r]),   .c_o (c_p[r])
      );
    end else begin : g_last
      bw_array_stage #(.W(W), .ROW(r)) u_stage (
        .clk (clk), .rst_n (rst_int_n),
        .v_i (v_p[r-1]), .a_i (a_p[r-1]), .b_i (b_p[r-1]),
        .s_i (s_p[r-1]), .c_i (c_p[r-1]),
        .v_o (v_p[r]),   .a_o (a_tail_unused), .b_o (b_tail_unused),
        .s_o (s_p[r]),   .c_o (c_p[r])
      );
    end
  end

  // ---------------- pipelined ripple adder ----------------
  logic          rv  [W+1];
  logic [TW-1:0] rs  [W+1];
  logic [TW-1:0] rc  [W];
  logic          rcy [W];
  logic [TW-1:0] c_tail_unused;
  logic          cy_tail_unused;

  assign rv[0]  = v_p[W-1];
  assign rs[0]  = s_p[W-1];
  assign rc[0]  = c_p[W-1];
  assign rcy[0] = 1'b0;

  for (genvar p = 0; p < W; p++) begin : g_rip
    if (p < W - 1) begin : g_mid
      bw_ripple_stage #(.W(W), .P(p)) u_slice (
        .clk (clk), .rst_n (rst_int_n),
        .v_i (rv[p]), .s_i (rs[p]), .c_i (rc[p]), .cy_i (rcy[p]),
        .v_o (rv[p+1]), .s_o (rs[p+1]), .c_o (rc[p+1]), .cy_o (rcy[p+1])
      );
    end else begin : g_last
      bw_ripple_stage #(.W(W), .P(p)) u_slice (
        .clk (clk), .rst_n (rst_int_n),
        .v_i (rv[p]), .s_i (rs[p]), .c_i (rc[p]), .cy_i (rcy[p]),
        .v_o (rv[p+1]), .s_o (rs[p+1]), .c_o (c_tail_unused),
        .cy_o (cy_tail_unused)
      );
    end
  end

  assign out_valid = rv[W];
  assign out_prod  = rs[W];

  // ---------------- occupancy tracking for the checks ----------------
  logic [CW-1:0] inflight, inflight_n;
  logic [CW-1:0] idle, idle_n;

  always_comb begin
    inflight_n = inflight + CW'(in_valid) - CW'(out_valid);
    if (in_valid)                idle_n = '0;
    else if (idle == CW'(LAT))   idle_n = idle;
    else                         idle_n = idle + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      inflight <= '0;
      idle     <= '0;
    end else begin
      inflight <= inflight_n;
      idle     <= idle_n;
    end
  end

  p_inflight_cap_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    inflight <= CW'(LAT));

  p_no_orphan_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_valid |-> inflight != '0);

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (idle == CW'(LAT)) |-> !out_valid);

endmodule

// File: tb/tb_bw_array_mult.sv
`timescale 1ns/1ps
module tb_bw_array_mult;

  localparam int W   = 8;
  localparam int TW  = 2 * W;
  localparam int LAT = 2 * W - 1;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [W-1:0]  in_a;
  logic [W-1:0]  in_b;
  logic          out_valid;
  logic [TW-1:0] out_prod;

  bw_array_mult #(.W(W)) dut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
    .in_a (in_a), .in_b (in_b), .out_valid (out_valid), .out_prod (out_prod)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int    checks = 0;
  int    errs   = 0;
  bit    mon_on = 1'b0;
  bit    done   = 1'b0;
  string cur_tag = "R7";

  // reference: delay line of what was offered at each edge
  bit            qv [$];
  logic [TW-1:0] qp [$];
  string         qt [$];
  bit            ev;
  logic [TW-1:0] ep;
  string         et;
  bit            ehave = 1'b0;

  function automatic logic [TW-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [TW-1:0] sa;
    logic signed [TW-1:0] sb;
    sa = $signed(a);
    sb = $signed(b);
    return sa * sb;
  endfunction

  task automatic chk(input string tag, input logic [TW-1:0] act, input logic [TW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    qv.push_back(in_valid && rst_n);
    qp.push_back(model(in_a, in_b));
    qt.push_back(cur_tag);
    if (qv.size() == LAT) begin
      ev    = qv.pop_front();
      ep    = qp.pop_front();
      et    = qt.pop_front();
      ehave = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (mon_on && ehave) begin
      // R2 timing (and R7 for empty slots) on the valid flag
      chk(ev ? "R2" : "R7", TW'(out_valid), TW'(ev));
      if (ev) chk(et, out_prod, ep);
    end
  end

  task automatic send(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_a     = a;
    in_b     = b;
    cur_tag  = tag;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_a     = W'($urandom);
      in_b     = W'($urandom);
      cur_tag  = "R7";
    end
  endtask

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc >= 50000 && !done) begin
      errs++;
      checks++;
      $display("FAIL R2 watchdog expired actual=%0d expected<50000", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  localparam logic [W-1:0] MINV = W'(1) << (W - 1);
  localparam logic [W-1:0] MAXV = MINV - 1'b1;

  initial begin
    logic [W-1:0] corner [5];
    corner[0] = '0;
    corner[1] = '1;
    corner[2] = W'(1);
    corner[3] = MAXV;
    corner[4] = MINV;

    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_a     = '0;
    in_b     = '0;
    // R4: output quiet while reset is held
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R4", TW'(out_valid), '0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    @(negedge clk);
    chk("R4", TW'(out_valid), '0);
    mon_on = 1'b1;

    // R5 / R6: corner operands back to back
    for (int i = 0; i < 5; i++) begin
      for (int j = 0; j < 5; j++) begin
        send(corner[i], corner[j], (i == 4 && j == 4) ? "R5" : "R6");
      end
    end
    idle(3);

    // R3: long unbroken random burst
    for (int i = 0; i < 200; i++) send(W'($urandom), W'($urandom), "R3");

    // R1 / R7: random traffic with random gaps
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 1) == 1) send(W'($urandom), W'($urandom), "R1");
      else idle(1);
    end

    idle(LAT + 4);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule